// File: doc/BRIEF.md
# Full-Speed USB Packet Receiver

This block takes the bit stream of a full-speed (12 Mbit/s) USB link after clock recovery and turns it into packet-level events. A strobe marks each recovered bit period. A separate flag reports a single-ended-zero line state. The receiver undoes the NRZI line coding and hunts for the synchronisation pattern. Once it finds the pattern, it strips stuffed bits, checks the packet identifier, and runs the CRC that matches the packet type. At the end of the packet it reports the packet identifier together with a good/bad verdict.

Token packets are compared against the programmed device address and the supported endpoint range. An accepted token raises a token strobe carrying the endpoint number. An accepted OUT or SETUP token arms the receiver for the data packet that follows. Only an armed data packet delivers its payload bytes, and it delivers them in order, one strobe per byte. The two CRC bytes never appear on the byte output. The payload is limited to a parameterised number of bytes, eight by default.

Top module: `usb_pkt_rx`

## Requirements
- R1: A packet is accepted only after at least SYNC_ZEROS (default 6) decoded zero bits followed by a decoded one. Without that pattern, the following bits and SE0 raise no strobe.
- R2: The line is NRZI coded with idle level J, meaning rx_dp high. A decoded 0 is a level change and a decoded 1 is no change. Bytes arrive least significant bit first.
- R3: After six consecutive decoded ones inside a packet, the next bit is a stuffed bit and is discarded. Payload bytes are delivered without it.
- R4: If the bit in the stuffed position is a one, that is a stuffing error and the packet's end status is bad.
- R5: The first byte after sync is the PID. Its upper nibble must equal the bitwise complement of its lower nibble. Otherwise the packet ends bad and delivers no data strobes.
- R6: A token has PID lower bits 01. Its body is 7 address bits, then 4 endpoint bits, then a 5-bit CRC with polynomial x^5+x^2+1. A token with a failing CRC ends bad and raises no tok_stb.
- R7: A data packet has PID lower bits 11. Its CRC16 (polynomial 0x8005) must leave the residual 0x800D. On a failed check the end status is bad.
- R8: An OUT (PID 0001) or SETUP (1101) token whose address differs from dev_addr ends good but raises no tok_stb. It also disarms the receiver, so the next data packet raises no data strobes.
- R9: A token whose endpoint is NUM_EP or higher raises no tok_stb.
- R10: A payload longer than MAX_PAYLOAD bytes ends bad. Only the first MAX_PAYLOAD bytes are strobed.
- R11: An SE0 inside a packet raises eop_stb for exactly one cycle, with pkt_pid and eop_ok. A handshake (PID lower bits 10) with no body ends good.
- R12: After reset, eop_stb, tok_stb, data_stb and pkt_pid are zero.
- R13: An armed data packet strobes its payload bytes in order and never its CRC bytes. A zero-length data packet ends good with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | One pulse per recovered bit period |
| rx_dp | input | 1 | Line level for this bit, 1 = J |
| rx_se0 | input | 1 | Bit period is single-ended zero |
| dev_addr | input | 7 | Programmed device address |
| pkt_pid | output | 4 | PID code of the last packet |
| eop_stb | output | 1 | End-of-packet pulse |
| eop_ok | output | 1 | Packet verdict, valid with eop_stb |
| tok_stb | output | 1 | Accepted token for this device |
| tok_ep | output | 4 | Endpoint of the accepted token |
| data_stb | output | 1 | Payload byte strobe |
| data_byte | output | 8 | Payload byte |

## Verification
A table of data payloads is sent, each preceded by an OUT token. The payloads include empty, single-byte, all-ones runs that force stuffing, mixed patterns, and a full eight-byte case. Comparing these shows whether destuffing, byte order and CRC-byte removal hold, independent of content. An oversize entry separates the length limit from the CRC check. Directed packets then each break one thing: a short sync, a non-complement PID, corrupted CRC5 and CRC16, a wrong address, an out-of-range endpoint, and a one in the stuffed position. Each of these shows that one check can fail the packet while the others still pass.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PID  = 2'd1,
        ST_BODY = 2'd2
    } rx_state_e;

    localparam logic [1:0] KIND_TOKEN = 2'b01;
    localparam logic [1:0] KIND_DATA  = 2'b11;
    localparam logic [1:0] KIND_HSHK  = 2'b10;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_SOF   = 4'b0101;
    localparam logic [3:0] PID_SETUP = 4'b1101;

endpackage

// File: rtl/usb_rx_line.sv
// NRZI decoder and bit destuffer for the receive path.
module usb_rx_line #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_stb,
    input  logic in_dp,
    input  logic in_se0,
    input  logic active,
    output logic bit_stb,
    output logic bit_val,
    output logic stuff_err,
    output logic eop_stb
);
    localparam int CW = $clog2(STUFF_RUN + 1);
    localparam logic [CW-1:0] RUN = CW'(STUFF_RUN);

    logic          level_d, level_q;
    logic [CW-1:0] ones_d, ones_q;
    logic          dec;

    always_comb begin
        dec       = (in_dp == level_q);
        level_d   = level_q;
        ones_d    = ones_q;
        bit_stb   = 1'b0;
        bit_val   = 1'b0;
        stuff_err = 1'b0;
        eop_stb   = 1'b0;
        if (in_stb) begin
            if (in_se0) begin
                eop_stb = 1'b1;
                level_d = 1'b1;
                ones_d  = '0;
            end else begin
                level_d = in_dp;
                if (active && ones_q == RUN) begin
                    // stuffed position: drop the bit, a one here is illegal
                    stuff_err = dec;
                    ones_d    = '0;
                end else begin
                    bit_stb = 1'b1;
                    bit_val = dec;
                    if (!dec)
                        ones_d = '0;
                    else if (ones_q != RUN)
                        ones_d = ones_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            ones_q  <= '0;
        end else begin
            level_q <= level_d;
            ones_q  <= ones_d;
        end
    end
endmodule

// File: rtl/usb_rx_crc.sv
// Serial CRC with all-ones preset and a residual compare.
module usb_rx_crc #(
    parameter int           W     = 5,
    parameter logic [W-1:0] POLY  = W'(5),
    parameter logic [W-1:0] RESID = W'(12)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic ok
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = din ^ crc_q[W-1];
        crc_d = crc_q;
        if (clr)
            crc_d = '1;
        else if (en)
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign ok = (crc_q == RESID);
endmodule

// File: rtl/usb_pkt_rx.sv
module usb_pkt_rx
    import usb_rx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 8,
    parameter int NUM_EP      = 4,
    parameter int SYNC_ZEROS  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_stb,
    input  logic       rx_dp,
    input  logic       rx_se0,
    input  logic [6:0] dev_addr,
    output logic [3:0] pkt_pid,
    output logic       eop_stb,
    output logic       eop_ok,
    output logic       tok_stb,
    output logic [3:0] tok_ep,
    output logic       data_stb,
    output logic [7:0] data_byte
);
    localparam int NBW = $clog2(MAX_PAYLOAD + 4);
    localparam int ZW  = $clog2(SYNC_ZEROS + 1);
    localparam logic [NBW-1:0] NB_CAP = NBW'(MAX_PAYLOAD + 3);
    localparam logic [NBW-1:0] NB_LIM = NBW'(MAX_PAYLOAD + 2);
    localparam logic [NBW-1:0] NB_TWO = NBW'(2);
    localparam logic [ZW-1:0]  Z_MIN  = ZW'(SYNC_ZEROS);

    typedef struct packed {
        rx_state_e      st;
        logic [ZW-1:0]  zc;
        logic [7:0]     sh;
        logic [2:0]     bc;
        logic [NBW-1:0] nb;
        logic [3:0]     pid;
        logic           pid_ok;
        logic           err;
        logic           armed;
        logic [7:0]     h0;
        logic [7:0]     h1;
        logic           o_data;
        logic [7:0]     o_byte;
        logic           o_eop;
        logic           o_ok;
        logic           o_tok;
        logic [3:0]     o_ep;
    } regs_t;

    regs_t r_d, r_q;

    logic ln_stb, ln_bit, ln_err, ln_eop;
    logic crc_clr, crc_en, crc5_ok, crc16_ok;

    usb_rx_line #(.STUFF_RUN(6)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_stb   (rx_stb),
        .in_dp    (rx_dp),
        .in_se0   (rx_se0),
        .active   (r_q.st != ST_HUNT),
        .bit_stb  (ln_stb),
        .bit_val  (ln_bit),
        .stuff_err(ln_err),
        .eop_stb  (ln_eop)
    );

    usb_rx_crc #(.W(5), .POLY(5'h05), .RESID(5'h0C)) u_crc5 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(ln_bit), .ok(crc5_ok)
    );

    usb_rx_crc #(.W(16), .POLY(16'h8005), .RESID(16'h800D)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(ln_bit), .ok(crc16_ok)
    );

    logic [1:0] kind;
    logic [7:0] byte_n;
    logic [6:0] t_addr;
    logic [3:0] t_ep;
    logic       len_ok, good, xfer_tok, match;

    always_comb begin
        kind     = r_q.pid[1:0];
        byte_n   = {ln_bit, r_q.sh[7:1]};
        t_addr   = r_q.h1[6:0];
        t_ep     = {r_q.h0[2:0], r_q.h1[7]};
        match    = (t_addr == dev_addr) && (int'(t_ep) < NUM_EP);
        xfer_tok = (kind == KIND_TOKEN) && (r_q.pid != PID_SOF);
        unique case (kind)
            KIND_TOKEN: len_ok = (r_q.nb == NB_TWO) && crc5_ok;
            KIND_DATA:  len_ok = (r_q.nb >= NB_TWO) && (r_q.nb <= NB_LIM) && crc16_ok;
            KIND_HSHK:  len_ok = (r_q.nb == '0);
            default:    len_ok = 1'b0;
        endcase
        good = (r_q.st == ST_BODY) && r_q.pid_ok && !r_q.err && (r_q.bc == 3'd0) && len_ok;

        r_d        = r_q;
        r_d.o_data = 1'b0;
        r_d.o_eop  = 1'b0;
        r_d.o_tok  = 1'b0;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;

        if (ln_err)
            r_d.err = 1'b1;

        if (ln_eop) begin
            if (r_q.st != ST_HUNT) begin
                r_d.o_eop = 1'b1;
                r_d.o_ok  = good;
                if (r_q.st == ST_BODY && r_q.pid_ok) begin
                    if (xfer_tok) begin
                        r_d.o_tok = good && match;
                        r_d.armed = good && match &&
                                    (r_q.pid == PID_OUT || r_q.pid == PID_SETUP);
                        if (good && match)
                            r_d.o_ep = t_ep;
                    end else if (kind == KIND_DATA) begin
                        r_d.armed = 1'b0;
                    end
                end
            end
            r_d.st = ST_HUNT;
            r_d.zc = '0;
        end else if (ln_stb) begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (!ln_bit) begin
                        if (r_q.zc != Z_MIN)
                            r_d.zc = r_q.zc + 1'b1;
                    end else begin
                        if (r_q.zc == Z_MIN) begin
                            r_d.st  = ST_PID;
                            r_d.bc  = '0;
                            r_d.nb  = '0;
                            r_d.err = 1'b0;
                            crc_clr = 1'b1;
                        end
                        r_d.zc = '0;
                    end
                end
                ST_PID: begin
                    r_d.sh = byte_n;
                    r_d.bc = r_q.bc + 1'b1;
                    if (r_q.bc == 3'd7) begin
                        r_d.pid    = byte_n[3:0];
                        r_d.pid_ok = (byte_n[7:4] == ~byte_n[3:0]);
                        r_d.st     = ST_BODY;
                    end
                end
                default: begin
                    crc_en = 1'b1;
                    r_d.sh = byte_n;
                    r_d.bc = r_q.bc + 1'b1;
                    if (r_q.bc == 3'd7) begin
                        r_d.h1 = r_q.h0;
                        r_d.h0 = byte_n;
                        if (r_q.nb != NB_CAP)
                            r_d.nb = r_q.nb + 1'b1;
                        if (kind == KIND_DATA && r_q.pid_ok && r_q.armed &&
                            r_q.nb >= NB_TWO && r_q.nb < NB_LIM) begin
                            r_d.o_data = 1'b1;
                            r_d.o_byte = r_q.h1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, default: '0};
        else        r_q <= r_d;
    end

    assign pkt_pid   = r_q.pid;
    assign eop_stb   = r_q.o_eop;
    assign eop_ok    = r_q.o_ok;
    assign tok_stb   = r_q.o_tok;
    assign tok_ep    = r_q.o_ep;
    assign data_stb  = r_q.o_data;
    assign data_byte = r_q.o_byte;
endmodule

// File: rtl/usb_pkt_rx_chk.sv
module usb_pkt_rx_chk #(
    parameter int MAX_PAYLOAD = 8,
    parameter int NUM_EP      = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       eop_stb,
    input logic       eop_ok,
    input logic       tok_stb,
    input logic [3:0] tok_ep,
    input logic       data_stb
);
    localparam int CW = $clog2(MAX_PAYLOAD + 2);
    localparam logic [CW-1:0] LIM = CW'(MAX_PAYLOAD);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         seen_q <= '0;
        else if (eop_stb)                   seen_q <= '0;
        else if (data_stb && seen_q != LIM) seen_q <= seen_q + 1'b1;
    end

    assert_eop_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eop_stb |=> !eop_stb);

    assert_tok_only_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tok_stb |-> (eop_stb && eop_ok));

    assert_tok_ep_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tok_stb |-> (int'(tok_ep) < NUM_EP));

    assert_payload_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> (seen_q < LIM));

    assert_byte_not_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> !eop_stb);

    assert_quiet_after_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!eop_stb && !tok_stb && !data_stb));
endmodule

bind usb_pkt_rx usb_pkt_rx_chk #(.MAX_PAYLOAD(MAX_PAYLOAD), .NUM_EP(NUM_EP)) u_chk (
    .clk(clk), .rst_n(rst_n), .eop_stb(eop_stb), .eop_ok(eop_ok),
    .tok_stb(tok_stb), .tok_ep(tok_ep), .data_stb(data_stb)
);

// File: tb/sim_usb_pkt_rx.sv
`timescale 1ns/1ps
module sim_usb_pkt_rx;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] DEV = 7'h2A;

    // {expect_ok, length, payload bytes (byte 0 in bits 7:0)}
    localparam logic [76:0] VEC [0:5] = '{
        {1'b1, 4'd0, 72'h0},
        {1'b1, 4'd1, 72'hA5},
        {1'b1, 4'd3, 72'h0000FFFF},
        {1'b1, 4'd8, 72'h0807060504030201},
        {1'b1, 4'd5, 72'h7E8000FF3C},
        {1'b0, 4'd9, 72'h998877665544332211}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_stb = 1'b0;
    logic       rx_dp = 1'b1;
    logic       rx_se0 = 1'b0;
    logic [6:0] dev_addr = DEV;
    logic [3:0] pkt_pid, tok_ep;
    logic       eop_stb, eop_ok, tok_stb, data_stb;
    logic [7:0] data_byte;

    int checks = 0;
    int errors = 0;

    usb_pkt_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_dp(rx_dp), .rx_se0(rx_se0),
        .dev_addr(dev_addr), .pkt_pid(pkt_pid), .eop_stb(eop_stb), .eop_ok(eop_ok),
        .tok_stb(tok_stb), .tok_ep(tok_ep), .data_stb(data_stb), .data_byte(data_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor, sampled away from the active edge
    logic [7:0] got [0:15];
    int n_data = 0, n_eop = 0, n_tok = 0;
    logic last_ok = 1'b0;
    logic [3:0] last_pid = 4'h0, last_ep = 4'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_stb) begin
                if (n_data < 16) got[n_data] = data_byte;
                n_data++;
            end
            if (eop_stb) begin
                n_eop++;
                last_ok  = eop_ok;
                last_pid = pkt_pid;
            end
            if (tok_stb) begin
                n_tok++;
                last_ep = tok_ep;
            end
        end
    end

    task automatic check(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic bits [0:511];
    int   nbits;
    logic lvl;

    task automatic clear_mon();
        n_data = 0; n_eop = 0; n_tok = 0;
    endtask

    task automatic add_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            bits[nbits] = v[i];
            nbits++;
        end
    endtask

    task automatic drive(input logic dp, input logic se0);
        @(negedge clk);
        rx_dp = dp; rx_se0 = se0; rx_stb = 1'b1;
        @(negedge clk);
        rx_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tx(input logic b);
        if (!b) lvl = ~lvl;
        drive(lvl, 1'b0);
    endtask

    // R2 line coding, R3 stuffing; stuff_bad puts a one in the first stuffed slot (R4)
    task automatic transmit(input logic stuff_bad);
        int ones = 0;
        logic injected = 1'b0;
        lvl = 1'b1;
        repeat (4) drive(1'b1, 1'b0);
        for (int i = 0; i < nbits; i++) begin
            tx(bits[i]);
            ones = bits[i] ? ones + 1 : 0;
            if (ones == 6) begin
                tx(stuff_bad && !injected);
                injected = 1'b1;
                ones = 0;
            end
        end
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b0);
        repeat (3) drive(1'b1, 1'b0);
    endtask

    function automatic logic [4:0] crc5(input logic [10:0] d);
        logic [4:0] c = 5'h1F;
        for (int i = 0; i < 11; i++) begin
            logic fb = d[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
        end
        return ~c;
    endfunction

    function automatic logic [15:0] crc16(input logic [71:0] p, input int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len * 8; i++) begin
            logic fb = p[i] ^ c[15];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
        return ~c;
    endfunction

    task automatic send_token(input logic [3:0] pid, input logic [6:0] addr,
                              input logic [3:0] ep, input logic bad_crc);
        logic [4:0] c = crc5({ep, addr});
        if (bad_crc) c[0] = ~c[0];
        nbits = 0;
        add_bits(32'h80, 8);
        add_bits({24'h0, ~pid, pid}, 8);
        add_bits({25'h0, addr}, 7);
        add_bits({28'h0, ep}, 4);
        for (int k = 4; k >= 0; k--) add_bits({31'h0, c[k]}, 1);
        transmit(1'b0);
    endtask

    task automatic send_data(input logic [7:0] pidbyte, input int len, input logic [71:0] p,
                             input logic bad_crc, input logic stuff_bad);
        logic [15:0] c = crc16(p, len);
        if (bad_crc) c[3] = ~c[3];
        nbits = 0;
        add_bits(32'h80, 8);
        add_bits({24'h0, pidbyte}, 8);
        for (int i = 0; i < len; i++) add_bits({24'h0, p[8*i +: 8]}, 8);
        for (int k = 15; k >= 0; k--) add_bits({31'h0, c[k]}, 1);
        transmit(stuff_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!eop_stb && !tok_stb && !data_stb, "R12 strobes", int'(eop_stb | tok_stb | data_stb), 0);
        check(pkt_pid == 4'h0, "R12 pid", int'(pkt_pid), 0);

        // table walk: OUT token then DATA0 (R2 R3 R7 R10 R13)
        for (int v = 0; v < 6; v++) begin
            logic       exp_ok = VEC[v][76];
            int         len    = int'(VEC[v][75:72]);
            logic [71:0] pay   = VEC[v][71:0];
            int         exp_n  = (len > 8) ? 8 : len;
            clear_mon();
            send_token(4'b0001, DEV, 4'd1, 1'b0);
            check(n_tok == 1 && last_ep == 4'd1, "R6 token accepted", n_tok, 1);
            clear_mon();
            send_data(8'hC3, len, pay, 1'b0, 1'b0);
            check(n_eop == 1 && last_ok == exp_ok, "R10 R11 data verdict", int'(last_ok), int'(exp_ok));
            check(n_data == exp_n, "R13 R10 byte count", n_data, exp_n);
            for (int b = 0; b < exp_n && b < n_data; b++)
                check(got[b] == pay[8*b +: 8], "R3 R13 byte value", int'(got[b]), int'(pay[8*b +: 8]));
        end

        // R1 short sync: no packet seen
        clear_mon();
        nbits = 0;
        add_bits(32'h8, 4);
        add_bits(32'hE1, 8);
        add_bits(32'h2A, 7);
        add_bits(32'h1, 4);
        add_bits(32'h1F, 5);
        transmit(1'b0);
        check(n_eop == 0 && n_tok == 0, "R1 short sync ignored", n_eop, 0);

        // R6 CRC5 corrupted
        clear_mon();
        send_token(4'b0001, DEV, 4'd2, 1'b1);
        check(n_eop == 1 && !last_ok && n_tok == 0, "R6 bad crc5", int'(last_ok), 0);

        // R9 endpoint out of range
        clear_mon();
        send_token(4'b0001, DEV, 4'd5, 1'b0);
        check(n_eop == 1 && last_ok && n_tok == 0, "R9 endpoint filtered", n_tok, 0);

        // R8 address mismatch disarms
        send_token(4'b1101, DEV, 4'd0, 1'b0);
        clear_mon();
        send_token(4'b0001, 7'h11, 4'd1, 1'b0);
        check(n_eop == 1 && last_ok && n_tok == 0, "R8 foreign token", n_tok, 0);
        clear_mon();
        send_data(8'hC3, 2, 72'h5A5A, 1'b0, 1'b0);
        check(n_eop == 1 && last_ok && n_data == 0, "R8 no strobes", n_data, 0);

        // R8 SETUP to own address, endpoint 0
        clear_mon();
        send_token(4'b1101, DEV, 4'd0, 1'b0);
        check(n_tok == 1 && last_ep == 4'd0 && last_pid == 4'b1101, "R8 setup accepted", n_tok, 1);

        // R7 CRC16 corrupted
        clear_mon();
        send_data(8'h4B, 2, 72'h1234, 1'b1, 1'b0);
        check(n_eop == 1 && !last_ok, "R7 bad crc16", int'(last_ok), 0);

        // R5 PID nibbles not complementary
        send_token(4'b0001, DEV, 4'd1, 1'b0);
        clear_mon();
        send_data(8'h33, 1, 72'h42, 1'b0, 1'b0);
        check(n_eop == 1 && !last_ok && n_data == 0, "R5 bad pid", int'(last_ok), 0);

        // R4 one in stuffed position
        send_token(4'b0001, DEV, 4'd1, 1'b0);
        clear_mon();
        send_data(8'hC3, 1, 72'hFF, 1'b0, 1'b1);
        check(n_eop == 1 && !last_ok, "R4 stuff error", int'(last_ok), 0);

        // R11 handshake with no body
        clear_mon();
        nbits = 0;
        add_bits(32'h80, 8);
        add_bits(32'hD2, 8);
        transmit(1'b0);
        check(n_eop == 1 && last_ok && last_pid == 4'b0010, "R11 handshake", int'(last_pid), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule